// File: doc/BRIEF.md
# Strobe-Driven Serial EEPROM Read Engine

This block is the device-side protocol engine of a 512-byte memory. A host reaches it over one data line, split here into pad-side `dq_in`, `dq_out` and `dq_oe`, and three active-low strobes: chip select, read enable and write enable. Each data bit takes one whole static bus cycle, not a free-running serial clock. The strobes that are low select the direction of that bit. All strobes are sampled by the block clock, and the host is assumed to hold each strobe level for at least two clock cycles.

A transfer starts with sixteen write cycles that carry an address, most significant bit first. Address bit 15 selects the operation. When it is clear, the engine returns the addressed byte over eight read cycles and then moves on to the following bytes without stopping. When it is set, the engine takes bytes from further write cycles and stores them at consecutive addresses. A write-protect input decides whether each byte may be stored. A cycle in the direction opposite to the current data phase works as a reset command and returns the engine to address entry. The storage is a plain register array, and the bench fills it through the write operation.

Top module: `strobe_serial_eeprom`

## Requirements
- R1: While `ce_n` is high, `dq_oe` is low and the engine state (phase, byte address, bit count) does not change.
- R2: In address entry, a write cycle (`ce_n`=0, `we_n`=0, `oe_n`=1) captures `dq_in` when `we_n` or `ce_n` rises. Sixteen such cycles form the address, MSB first. Bits 8..0 select the byte. Bits 14..9 are ignored. Bit 15 picks a read (0) or a write (1).
- R3: In the read phase, each read cycle (`ce_n`=0, `oe_n`=0, `we_n`=1) presents one bit of the current byte on `dq_out`, MSB first, with `dq_oe` high. `dq_oe` is low at all other times.
- R4: After the eighth bit of a byte, the byte address advances by one and wraps from 511 to 0. This holds for both reads and writes.
- R5: In the write phase, each group of eight write cycles forms a byte, MSB first. The byte is stored at the current byte address, and the address then advances.
- R6: `wp` is sampled when the first bit of each written byte is captured. If it is low, that byte is not stored. A fall of `wp` later in the byte does not stop that byte.
- R7: A cycle with `ce_n`, `we_n` and `oe_n` all low is illegal. `dq_oe` stays low and `bad_cycle` rises. The cycle, and any cycle that follows it before both `we_n` and `oe_n` are high again or `ce_n` is high, neither shifts nor counts.
- R8: A write cycle during the read phase, or a read cycle during the write phase, returns the engine to address entry and discards its bit. A read cycle during address entry restarts the address count.
- R9: Any number of clock cycles may pass between bus cycles while `ce_n` is high without loss of address or bit position.
- R10: After reset, the engine is in address entry, `dq_oe` is low and `bad_cycle` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read enable, active low |
| we_n | input | 1 | Write enable, active low |
| wp | input | 1 | Write permit. Low blocks new byte stores |
| dq_in | input | 1 | Data line value as seen at the pad |
| dq_out | output | 1 | Data bit presented for the pad driver |
| dq_oe | output | 1 | Pad driver enable for the data line |
| bad_cycle | output | 1 | High after an illegal strobe combination until the bus is idle |

## Verification
The assertions assume that the strobes are already synchronous to `clk` and that every strobe level lasts at least two clock cycles. With that, a strobe edge is never missed, and a cycle end is seen exactly once. The bench drives every strobe change on a falling clock edge and holds each level for two or more clocks. It also samples `dq_out` and `dq_oe` inside the held window, so the state behind them is settled when it is read. Long idle gaps are inserted on purpose to exercise the static-protocol requirement within those same assumptions.

// File: rtl/sse_pkg.sv
// Shared types for the strobe-driven serial memory engine.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sse_pkg;
    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_t;
endpackage

// File: rtl/sse_strobe_dec.sv
// Decodes the three active-low strobes into single-cycle "cycle ended"
// pulses. It also tracks illegal combinations, which spoil the cycle in
// progress until the bus goes idle.
// Assumes the strobes are synchronous to clk and each level lasts at least
// two clocks.
module sse_strobe_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic din,
    output logic wr_end,
    output logic rd_end,
    output logic rd_live,
    output logic spoiled,
    output logic din_q
);
    logic wr_act, rd_act, ill, idle;
    logic wr_prev, rd_prev;

    // Classify the present strobe combination.
    always_comb begin
        wr_act = !ce_n && !we_n &&  oe_n;
        rd_act = !ce_n && !oe_n &&  we_n;
        ill    = !ce_n && !we_n && !oe_n;
        idle   =  ce_n || (we_n && oe_n);
    end

    // Remember last cycle's activity, the spoil state and the written bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev <= 1'b0;
            rd_prev <= 1'b0;
            spoiled <= 1'b0;
            din_q   <= 1'b0;
        end else begin
            wr_prev <= wr_act;
            rd_prev <= rd_act;
            if (ill)       spoiled <= 1'b1;
            else if (idle) spoiled <= 1'b0;
            if (wr_act)    din_q <= din;
        end
    end

    // A cycle ends when its activity drops without entering an illegal state.
    always_comb begin
        wr_end  = wr_prev && !wr_act && !ill && !spoiled;
        rd_end  = rd_prev && !rd_act && !ill && !spoiled;
        rd_live = rd_act && !spoiled;
    end
endmodule

// File: rtl/sse_seq.sv
// Protocol sequencer: address entry, sequential read and byte-write phases.
// It keeps the byte address, the bit count and the write-permit latch.
// Assumes MEM_DEPTH <= 2**IDX_W and DATA_W <= ADDR_BITS.
module sse_seq
    import sse_pkg::*;
#(
    parameter int ADDR_BITS = 16,
    parameter int DATA_W    = 8,
    parameter int MEM_DEPTH = 512,
    parameter int IDX_W     = 9,
    localparam int CNT_W    = $clog2(ADDR_BITS + 1),
    localparam int SEL_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_end,
    input  logic              rd_end,
    input  logic              din_q,
    input  logic              wp,
    output phase_t            phase,
    output logic [IDX_W-1:0]  byte_addr,
    output logic [SEL_W-1:0]  rd_sel,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              addr_inc
);
    logic [ADDR_BITS-1:0] shreg;
    logic [ADDR_BITS-1:0] next_shreg;
    logic [CNT_W-1:0]     cnt;
    logic                 wr_ok;
    logic                 addr_last, byte_last;
    logic [IDX_W-1:0]     next_addr;

    // Shift-in value, bit position tests and wrapped next address.
    always_comb begin
        next_shreg = {shreg[ADDR_BITS-2:0], din_q};
        addr_last  = (cnt == CNT_W'(ADDR_BITS - 1));
        byte_last  = (cnt == CNT_W'(DATA_W - 1));
        next_addr  = (byte_addr == IDX_W'(MEM_DEPTH - 1)) ? '0 : byte_addr + 1'b1;
        rd_sel     = SEL_W'(DATA_W - 1) - cnt[SEL_W-1:0];
        mem_wdata  = next_shreg[DATA_W-1:0];
        mem_we     = (phase == PH_WRITE) && wr_end && byte_last && wr_ok;
        addr_inc   = ((phase == PH_READ)  && rd_end && byte_last) ||
                     ((phase == PH_WRITE) && wr_end && byte_last);
    end

    // Phase transitions, shifting and counting on each completed bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_ADDR;
            shreg     <= '0;
            cnt       <= '0;
            byte_addr <= '0;
            wr_ok     <= 1'b0;
        end else begin
            case (phase)
                PH_ADDR: begin
                    if (wr_end) begin
                        shreg <= next_shreg;
                        if (addr_last) begin
                            cnt       <= '0;
                            byte_addr <= next_shreg[IDX_W-1:0];
                            phase     <= next_shreg[ADDR_BITS-1] ? PH_WRITE : PH_READ;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else if (rd_end) begin
                        cnt <= '0;
                    end
                end
                PH_READ: begin
                    if (wr_end) begin
                        phase <= PH_ADDR;
                        cnt   <= '0;
                    end else if (rd_end) begin
                        if (byte_last) begin
                            cnt       <= '0;
                            byte_addr <= next_addr;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_WRITE: begin
                    if (rd_end) begin
                        phase <= PH_ADDR;
                        cnt   <= '0;
                    end else if (wr_end) begin
                        shreg <= next_shreg;
                        if (cnt == '0) wr_ok <= wp;
                        if (byte_last) begin
                            cnt       <= '0;
                            byte_addr <= next_addr;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: phase <= PH_ADDR;
            endcase
        end
    end
endmodule

// File: rtl/sse_array.sv
// Byte storage: one write port and an asynchronous read at the same index.
// The contents are not reset. Assumes the host writes a byte before it
// reads it.
module sse_array #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store a completed byte.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Present the addressed byte.
    assign rdata = mem[idx];
endmodule

// File: rtl/strobe_serial_eeprom.sv
// Top level of the strobe-driven serial memory engine. It joins the strobe
// decoder, the sequencer and the byte array, and drives the pad-side data
// enable only during a live read cycle in the read phase.
// Assumes the strobes are synchronous to clk.
module strobe_serial_eeprom
    import sse_pkg::*;
#(
    parameter int ADDR_BITS = 16,
    parameter int DATA_W    = 8,
    parameter int MEM_DEPTH = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic wp,
    input  logic dq_in,
    output logic dq_out,
    output logic dq_oe,
    output logic bad_cycle
);
    localparam int IDX_W = $clog2(MEM_DEPTH);
    localparam int SEL_W = $clog2(DATA_W);

    logic              wr_end, rd_end, rd_live, din_q;
    phase_t            phase;
    logic [IDX_W-1:0]  byte_addr;
    logic [SEL_W-1:0]  rd_sel;
    logic              mem_we, addr_inc;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    sse_strobe_dec u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .din(dq_in), .wr_end(wr_end), .rd_end(rd_end), .rd_live(rd_live),
        .spoiled(bad_cycle), .din_q(din_q)
    );

    sse_seq #(
        .ADDR_BITS(ADDR_BITS), .DATA_W(DATA_W),
        .MEM_DEPTH(MEM_DEPTH), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .rd_end(rd_end),
        .din_q(din_q), .wp(wp), .phase(phase), .byte_addr(byte_addr),
        .rd_sel(rd_sel), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .addr_inc(addr_inc)
    );

    sse_array #(.DEPTH(MEM_DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .we(mem_we), .idx(byte_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    // Pad-side outputs: the selected bit, enabled only for a live read.
    always_comb begin
        dq_out = mem_rdata[rd_sel];
        dq_oe  = rd_live && (phase == PH_READ);
    end
endmodule

// File: rtl/sse_checker.sv
// Property checker for strobe_serial_eeprom, attached by bind.
// Assumes the strobes are synchronous to clk.
module sse_checker
    import sse_pkg::*;
#(
    parameter int MEM_DEPTH = 512,
    parameter int IDX_W     = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             oe_n,
    input logic             we_n,
    input logic             dq_oe,
    input logic             mem_we,
    input logic             addr_inc,
    input phase_t           phase,
    input logic [IDX_W-1:0] byte_addr
);
    // R1: a deselected chip never drives the line.
    a_r1_hiz_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dq_oe);

    // R1: a deselected chip holds its position.
    a_r1_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && $past(ce_n)) |=> ($stable(byte_addr) && $stable(phase)));

    // R3: the driver is enabled only inside a read cycle.
    a_r3_oe_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!ce_n && !oe_n && we_n && phase == PH_READ));

    // R7: an illegal strobe combination keeps the line undriven.
    a_r7_hiz_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n && !oe_n) |-> !dq_oe);

    // R4: the last byte address wraps to zero.
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_inc && byte_addr == IDX_W'(MEM_DEPTH - 1)) |=> (byte_addr == '0));

    // R5: stores happen only in the write phase.
    a_r5_store_phase: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (phase == PH_WRITE));
endmodule

bind strobe_serial_eeprom sse_checker #(.MEM_DEPTH(MEM_DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dq_oe(dq_oe), .mem_we(mem_we), .addr_inc(addr_inc),
    .phase(phase), .byte_addr(byte_addr)
);

// File: tb/sim_strobe_serial_eeprom.sv
module sim_strobe_serial_eeprom;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp = 1'b1, dq_in = 1'b0;
    logic dq_out, dq_oe, bad_cycle;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    strobe_serial_eeprom u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wp(wp), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .bad_cycle(bad_cycle)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic wcyc(input logic b);
        @(negedge clk);
        dq_in = b; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rcyc(output logic b, output logic oe);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        b = dq_out; oe = dq_oe;
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_addr(input logic [15:0] a, input int gap);
        for (int i = 15; i >= 0; i--) begin
            wcyc(a[i]);
            idle(gap);
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        for (int i = 7; i >= 0; i--) wcyc(d[i]);
    endtask

    task automatic read_bits(input int n, input int gap, output logic [7:0] d, output bit all_oe);
        logic b, o;
        d = '0; all_oe = 1'b1;
        for (int i = 0; i < n; i++) begin
            rcyc(b, o);
            d = {d[6:0], b};
            all_oe = all_oe & o;
            idle(gap);
        end
    endtask

    // R10 and R1: reset state and deselected behaviour.
    task automatic t_reset;
        check(dq_oe == 1'b0, "R10 dq_oe after reset", dq_oe, 0);
        check(bad_cycle == 1'b0, "R10 bad_cycle after reset", bad_cycle, 0);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        check(dq_oe == 1'b0, "R1 no drive while deselected", dq_oe, 0);
        idle(2);
    endtask

    // R5, R4, R3: write across the wrap point, then read it back in sequence.
    task automatic t_write_wrap;
        logic [7:0] d; bit o; logic b, ob;
        wp = 1'b1;
        send_addr(16'h81FE, 0);
        write_byte(8'hA5); write_byte(8'h3C); write_byte(8'h96);
        rcyc(b, ob);
        check(ob == 1'b0, "R8 read in write phase not driven", ob, 0);
        send_addr(16'h01FE, 0);
        read_bits(8, 0, d, o);
        check(d == 8'hA5, "R3 first byte MSB first", d, 8'hA5);
        check(o == 1'b1, "R3 dq_oe during read cycles", o, 1);
        read_bits(8, 0, d, o);
        check(d == 8'h3C, "R5 sequential second byte", d, 8'h3C);
        read_bits(8, 0, d, o);
        check(d == 8'h96, "R4 wrap 511 to 0", d, 8'h96);
    endtask

    // R8, R2: reset command from the read phase, upper address bits ignored.
    task automatic t_upper_ignored;
        logic [7:0] d; bit o;
        wcyc(1'b1);
        send_addr(16'h7FFE, 0);
        read_bits(8, 0, d, o);
        check(d == 8'hA5, "R2 bits 14..9 ignored / R8 reset command", d, 8'hA5);
    endtask

    // R6: write protect blocks a byte, and a fall mid-byte does not.
    task automatic t_wp;
        logic [7:0] d; bit o; logic b, ob;
        wcyc(1'b0);
        send_addr(16'h8010, 0); write_byte(8'h11);
        rcyc(b, ob);
        wp = 1'b0;
        send_addr(16'h8010, 0); write_byte(8'hEE);
        rcyc(b, ob);
        wp = 1'b1;
        send_addr(16'h0010, 0);
        read_bits(8, 0, d, o);
        check(d == 8'h11, "R6 store blocked while wp low", d, 8'h11);
        wcyc(1'b0);
        send_addr(16'h8020, 0); write_byte(8'h5A); write_byte(8'h6B);
        rcyc(b, ob);
        send_addr(16'h8020, 0);
        for (int i = 7; i >= 0; i--) begin
            if (i == 4) wp = 1'b0;
            wcyc(d[0] ^ d[0] ^ 8'hC3 >> i);
        end
        write_byte(8'hD4);
        rcyc(b, ob);
        wp = 1'b1;
        send_addr(16'h0020, 0);
        read_bits(8, 0, d, o);
        check(d == 8'hC3, "R6 wp fall mid-byte has no effect", d, 8'hC3);
        read_bits(8, 0, d, o);
        check(d == 8'h6B, "R6 next byte blocked after wp fall", d, 8'h6B);
    endtask

    // R7: illegal cycle is flagged, undriven and ignored.
    task automatic t_illegal;
        logic [7:0] d, d2; bit o;
        wcyc(1'b0);
        send_addr(16'h0020, 0);
        read_bits(2, 0, d, o);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        check(dq_oe == 1'b0, "R7 no drive on illegal cycle", dq_oe, 0);
        check(bad_cycle == 1'b1, "R7 bad_cycle raised", bad_cycle, 1);
        idle(3);
        check(bad_cycle == 1'b0, "R7 bad_cycle clears when idle", bad_cycle, 0);
        read_bits(6, 0, d2, o);
        d = {d[1:0], d2[5:0]};
        check(d == 8'hC3, "R7 illegal cycle not counted", d, 8'hC3);
        read_bits(8, 0, d, o);
        check(d == 8'h6B, "R7 illegal cycle not a reset", d, 8'h6B);
    endtask

    // R8: a read cycle during address entry restarts the count.
    task automatic t_abort;
        logic [7:0] d; bit o; logic b, ob;
        wcyc(1'b0);
        for (int i = 0; i < 5; i++) wcyc(1'b1);
        rcyc(b, ob);
        check(ob == 1'b0, "R8 no drive during address entry", ob, 0);
        send_addr(16'h01FF, 0);
        read_bits(8, 0, d, o);
        check(d == 8'h3C, "R8 address restart after read cycle", d, 8'h3C);
    endtask

    // R9: long idle gaps between every bus cycle.
    task automatic t_static;
        logic [7:0] d; bit o;
        wcyc(1'b0);
        idle(60);
        send_addr(16'h0000, 40);
        read_bits(8, 40, d, o);
        check(d == 8'h96, "R9 static protocol survives idle gaps", d, 8'h96);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_wrap();
        t_upper_ignored();
        t_wp();
        t_illegal();
        t_abort();
        t_static();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule